// File: doc/BRIEF.md
# Protected Call Depth Tracker

This block counts how deeply secure calls are nested. Each secure-call pulse raises a 12-bit depth pointer by one, and each secure-return pulse lowers it by one. The block holds two programmable levels and compares the pointer against both. The lower level drives an early-warning interrupt. The upper level drives an overflow non-maskable interrupt. Software can use either one to act before the real stack runs out.

A small 32-bit register port lets software read the pointer and both levels at any time. Software may load the pointer or either level only while the permission input is high. A write made without permission changes nothing and raises a one-cycle access-violation flag. A return at depth zero leaves the pointer at zero and raises a one-cycle underflow flag.

Top module: `call_depth_tracker`

## Requirements
- R1: After reset the pointer reads 0, the warning level reads 0x00C, the maximum level reads 0x010, and warn_irq, ovf_nmi, underflow_err and acc_violation are low.
- R2: A call pulse alone raises the pointer by one at the next clock edge. A return pulse alone lowers it by one. Call and return in the same cycle leave the pointer unchanged.
- R3: A call at pointer value 0xFFF leaves the pointer at 0xFFF.
- R4: A return alone at pointer value 0 leaves the pointer at 0 and sets underflow_err high for exactly the following cycle.
- R5: warn_irq is high exactly while the pointer is greater than or equal to the warning level.
- R6: ovf_nmi is high exactly while the pointer is greater than or equal to the maximum level.
- R7: The word address selects the register: 0 is the pointer, 1 is the warning level, 2 is the maximum level, and 3 reads as zero. Each value sits in rdata bits 11:0, and bits 31:12 read as zero. Reads are combinational.
- R8: A write with wr_permit high loads wdata bits 11:0 into the addressed register at the next edge. A pointer write takes priority over a call or return in the same cycle.
- R9: A write with wr_permit low changes no register and sets acc_violation high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_pulse | input | 1 | Secure call taken this cycle |
| ret_pulse | input | 1 | Secure return taken this cycle |
| wr_permit | input | 1 | Security permission for register writes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| warn_irq | output | 1 | Early-warning interrupt |
| ovf_nmi | output | 1 | Overflow non-maskable interrupt |
| underflow_err | output | 1 | One-cycle pulse after a return at depth zero |
| acc_violation | output | 1 | One-cycle pulse after a write without permission |

## Verification
The bench drives the pointer one step below and onto each level, so a comparator built with a strict greater-than would raise each interrupt one call too late. It applies a call and a return together, which catches a design that lets one of them win. It drives the pointer to both ends of its range, so a counter that wraps would read 0x000 or 0xFFF where the requirements call for the held value. It also drives a write without permission, which a design that ignores the permission input would store, and a permitted pointer write applied together with a call, which a design with the wrong priority would overrun by one.

// File: rtl/call_depth_tracker.sv
module call_depth_tracker #(
  parameter int PTR_W = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter logic [PTR_W-1:0] WARN_RST = 12'h00C,
  parameter logic [PTR_W-1:0] MAX_RST = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_pulse,
  input  logic              ret_pulse,
  input  logic              wr_permit,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              warn_irq,
  output logic              ovf_nmi,
  output logic              underflow_err,
  output logic              acc_violation
);
  localparam logic [PTR_W-1:0] PTR_TOP = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] PTR_ZERO = '0;
  localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WARN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MAX = ADDR_W'(2);

  logic [PTR_W-1:0] ptr_q, warn_q, max_q;
  logic wr_ok, wr_ptr, go_up, go_down;

  assign wr_ok = reg_wr & wr_permit;
  assign wr_ptr = wr_ok && (reg_addr == A_PTR);
  assign go_up = call_pulse & ~ret_pulse;
  assign go_down = ret_pulse & ~call_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= PTR_ZERO;
    end else if (wr_ptr) begin
      ptr_q <= reg_wdata[PTR_W-1:0];
    end else if (go_up && ptr_q != PTR_TOP) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end else if (go_down && ptr_q != PTR_ZERO) begin
      ptr_q <= ptr_q - PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_q <= WARN_RST;
      max_q <= MAX_RST;
    end else if (wr_ok) begin
      if (reg_addr == A_WARN) warn_q <= reg_wdata[PTR_W-1:0];
      if (reg_addr == A_MAX) max_q <= reg_wdata[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underflow_err <= 1'b0;
      acc_violation <= 1'b0;
    end else begin
      underflow_err <= go_down && !wr_ptr && ptr_q == PTR_ZERO;
      acc_violation <= reg_wr & ~wr_permit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PTR:   reg_rdata[PTR_W-1:0] = ptr_q;
      A_WARN:  reg_rdata[PTR_W-1:0] = warn_q;
      A_MAX:   reg_rdata[PTR_W-1:0] = max_q;
      default: reg_rdata = '0;
    endcase
  end

  assign warn_irq = ptr_q >= warn_q;
  assign ovf_nmi = ptr_q >= max_q;
endmodule

// File: rtl/call_depth_tracker_sva.sv
module call_depth_tracker_sva #(
  parameter int PTR_W = 12,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_pulse,
  input logic              ret_pulse,
  input logic              wr_permit,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PTR_W-1:0]  ptr,
  input logic [PTR_W-1:0]  warn_thr,
  input logic [PTR_W-1:0]  max_thr,
  input logic              warn_irq,
  input logic              ovf_nmi,
  input logic              underflow_err,
  input logic              acc_violation
);
  logic sw_ptr;
  assign sw_ptr = reg_wr && wr_permit && reg_addr == '0;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_ptr |=> (ptr == $past(ptr) || ptr == $past(ptr) + PTR_W'(1) || ptr == $past(ptr) - PTR_W'(1)));

  assert_call_ret_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (call_pulse && ret_pulse && !sw_ptr) |=> $stable(ptr));

  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (call_pulse && !ret_pulse && !sw_ptr && ptr == {PTR_W{1'b1}}) |=> ptr == {PTR_W{1'b1}});

  assert_underflow_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |-> ($past(ret_pulse) && !$past(call_pulse) && $past(ptr) == '0 && ptr == '0));

  assert_warn_before_nmi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_thr <= max_thr && ovf_nmi) |-> warn_irq);

  assert_nmi_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_nmi) |-> ($past(call_pulse) || $past(reg_wr && wr_permit)));

  assert_no_perm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wr_permit) |=> ($stable(warn_thr) && $stable(max_thr)));

  assert_violation_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wr_permit) |=> acc_violation);
endmodule

bind call_depth_tracker call_depth_tracker_sva #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .call_pulse(call_pulse), .ret_pulse(ret_pulse),
  .wr_permit(wr_permit), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ptr(ptr_q), .warn_thr(warn_q), .max_thr(max_q),
  .warn_irq(warn_irq), .ovf_nmi(ovf_nmi),
  .underflow_err(underflow_err), .acc_violation(acc_violation)
);

// File: tb/call_depth_tracker_tb.sv
module call_depth_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic call_pulse = 0, ret_pulse = 0, wr_permit = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic warn_irq, ovf_nmi, underflow_err, acc_violation;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  call_depth_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .call_pulse(call_pulse), .ret_pulse(ret_pulse),
    .wr_permit(wr_permit), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .warn_irq(warn_irq),
    .ovf_nmi(ovf_nmi), .underflow_err(underflow_err), .acc_violation(acc_violation)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic r);
    call_pulse = c; ret_pulse = r;
    @(posedge clk); #1;
    call_pulse = 0; ret_pulse = 0; reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic perm);
    reg_addr = a; reg_wdata = d; wr_permit = perm; reg_wr = 1;
    step(0, 0);
    wr_permit = 0;
  endtask

  task automatic t_reset;
    rd(0, "R1 ptr", 0);
    rd(1, "R1 warn level", 32'h00C);
    rd(2, "R1 max level", 32'h010);
    check("R1 outputs", {warn_irq, ovf_nmi, underflow_err, acc_violation}, 0);
    rd(3, "R7 addr3 zero", 0);
  endtask

  task automatic t_climb;
    for (int i = 0; i < 11; i++) step(1, 0);
    rd(0, "R2 ptr after 11 calls", 11);
    check("R5 warn below level", warn_irq, 0);
    step(1, 0);
    check("R5 warn at level", warn_irq, 1);
    for (int i = 0; i < 3; i++) step(1, 0);
    check("R6 nmi below max", ovf_nmi, 0);
    step(1, 0);
    check("R6 nmi at max", ovf_nmi, 1);
    step(1, 1);
    rd(0, "R2 call+return unchanged", 16);
    step(0, 1);
    rd(0, "R2 return decrements", 15);
    check("R6 nmi drops", ovf_nmi, 0);
  endtask

  task automatic t_noperm;
    wr(1, 32'h5, 0);
    check("R9 violation pulse", acc_violation, 1);
    rd(1, "R9 warn unchanged", 32'h00C);
    step(0, 0);
    check("R9 violation one cycle", acc_violation, 0);
    wr(0, 32'h3, 0);
    rd(0, "R9 ptr unchanged", 15);
  endtask

  task automatic t_saturate;
    reg_addr = 0; reg_wdata = 32'hFFE; wr_permit = 1; reg_wr = 1;
    step(1, 0);
    wr_permit = 0;
    rd(0, "R8 write beats call", 32'hFFE);
    step(1, 0);
    rd(0, "R3 reach top", 32'hFFF);
    step(1, 0);
    rd(0, "R3 saturate", 32'hFFF);
  endtask

  task automatic t_levels;
    wr(1, 32'hABCDE100, 1);
    rd(1, "R7 upper bits zero", 32'h100);
    wr(2, 32'h200, 1);
    rd(2, "R8 max written", 32'h200);
    wr(0, 32'h1FF, 1);
    check("R5 warn over level", warn_irq, 1);
    check("R6 nmi under max", ovf_nmi, 0);
    step(1, 0);
    check("R6 nmi at new max", ovf_nmi, 1);
  endtask

  task automatic t_underflow;
    wr(0, 32'h0, 1);
    check("R4 no pulse on write", underflow_err, 0);
    step(0, 1);
    check("R4 underflow pulse", underflow_err, 1);
    rd(0, "R4 ptr stays zero", 0);
    step(0, 0);
    check("R4 pulse one cycle", underflow_err, 0);
    check("R5 warn clear at zero", warn_irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_climb;
    t_noperm;
    t_saturate;
    t_levels;
    t_underflow;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule